// File: doc/BRIEF.md
# Dual-Half NAND Page Hamming ECC Engine

This engine sits in the data path of a NAND flash bridge. It watches the bytes of a 512-byte page chunk as they pass and builds single-error-correcting Hamming parity for them. The chunk is split into two halves of 256 bytes. Each half produces 16 line parity bits, chosen by the byte index, and 6 column parity bits, chosen by the bit position. Software finds and repairs a flipped bit by comparing the stored ECC with a freshly computed one. The engine only produces the parity. It does not correct data.

The engine is driven by 8-bit mode codes written to the bridge's mode register. The clear code zeroes the accumulators. The bridge then needs one throw-away read of the data register before any byte can count. The calculate code starts accumulation over the streamed bytes. The result code turns the data register into a readout of six ECC bytes, delivered as three 16-bit words. The normal data code returns the engine to idle. Parity is held inverted, so an erased page of all 0xFF bytes yields an ECC of all 0xFF.

Top module: `nand_ecc_engine`

## Requirements
- R1: After reset the engine is in data mode, `rd_data` is 0, the byte counter is 0 and the engine is not armed. Entering result mode straight after reset reads 0xFFFF in all three words.
- R2: Writing mode 0xF4 clears both halves' parity, clears the byte counter and disarms the engine.
- R3: While disarmed, streamed bytes are ignored. The first `rd_req` after a clear arms the engine.
- R4: Only in calculate mode (entered by writing 0xB4) and only while armed does a byte presented with `data_valid` enter the parity.
- R5: For each byte index bit k (k = 0..7) within a half, line parity bit 2k+1 is the XOR of the bit-parity of every byte whose index has bit k set. Line parity bit 2k is the same XOR over the bytes whose index has bit k clear.
- R6: For m = 0..2, column parity bit 2m+1 is the XOR of every data bit whose bit position has bit m set. Column parity bit 2m is the same XOR over the positions with bit m clear. The column byte carries CP5..CP0 in bits 7..2 and has bits 1..0 fixed at 1.
- R7: All parity is presented inverted, so a page of all 0xFF bytes (or no bytes at all) gives 0xFF in every ECC byte.
- R8: Accepted bytes 0..255 go to half 0 and bytes 256..511 go to half 1. Any byte after the 512th is ignored.
- R9: Word 0 is {half0 LP15..8, half0 LP7..0}. Word 1 is {half1 LP7..0, half0 column byte}. Word 2 is {half1 column byte, half1 LP15..8}. The high byte is written first.
- R10: Writing 0xD4 enters result mode with the word pointer at 0. Each `rd_req` in result mode advances the pointer 0, 1, 2 and back to 0.
- R11: Writing 0x94 returns the engine to data mode. There `rd_data` is 0 and streamed bytes are ignored, and the held parity is kept for a later readout.
- R12: Any other mode code leaves the engine's mode, parity and pointer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_we | input | 1 | Mode register write strobe |
| mode_wdata | input | 8 | Mode code written |
| data_valid | input | 1 | A page byte passes through this cycle |
| data_byte | input | 8 | The page byte |
| rd_req | input | 1 | Data register read strobe |
| rd_data | output | 16 | ECC result word in result mode, 0 otherwise |

## Verification
On every cycle the assertions check the following: the word pointer never leaves 0..2 and steps in its wrap order on each read in result mode; the byte counter never passes 512; a disarmed engine always has an empty counter; a clear write leaves the engine empty and disarmed; `rd_data` is 0 outside result mode; and the column word always carries the two fixed one bits. The parity values themselves, the half split and the word packing can only be shown by the bench's scenarios. These scenarios compare full-page readouts against an independent model over single-bit sweeps at the half boundaries and over patterned pages. They also cover bytes dropped before the dummy read, bytes dropped past 512 and bytes dropped in data mode, plus the effect of unknown mode codes.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;

  localparam logic [7:0] CODE_DATA   = 8'h94;
  localparam logic [7:0] CODE_CALC   = 8'hB4;
  localparam logic [7:0] CODE_RESULT = 8'hD4;
  localparam logic [7:0] CODE_CLEAR  = 8'hF4;

  typedef enum logic [1:0] {
    ENG_DATA   = 2'd0,
    ENG_CALC   = 2'd1,
    ENG_RESULT = 2'd2
  } eng_mode_e;

endpackage

// File: rtl/nand_ecc_ctrl.sv
module nand_ecc_ctrl
  import nand_ecc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_we,
  input  logic [7:0] mode_wdata,
  input  logic       rd_req,
  output eng_mode_e  mode_q,
  output logic       armed_q,
  output logic [1:0] ptr_q,
  output logic       clr
);

  eng_mode_e  mode_d;
  logic       armed_d;
  logic [1:0] ptr_d;
  logic       mode_en;
  logic       enter_res;

  always_comb begin
    clr       = mode_we && (mode_wdata == CODE_CLEAR);
    enter_res = mode_we && (mode_wdata == CODE_RESULT);
    mode_en   = 1'b0;
    mode_d    = mode_q;
    if (mode_we) begin
      case (mode_wdata)
        CODE_DATA:   begin mode_d = ENG_DATA;   mode_en = 1'b1; end
        CODE_CALC:   begin mode_d = ENG_CALC;   mode_en = 1'b1; end
        CODE_RESULT: begin mode_d = ENG_RESULT; mode_en = 1'b1; end
        CODE_CLEAR:  begin mode_d = ENG_DATA;   mode_en = 1'b1; end
        default:     begin mode_d = mode_q;     mode_en = 1'b0; end
      endcase
    end
  end

  always_comb begin
    armed_d = armed_q;
    if (clr)
      armed_d = 1'b0;
    else if (rd_req && !armed_q)
      armed_d = 1'b1;
  end

  always_comb begin
    ptr_d = ptr_q;
    if (enter_res)
      ptr_d = 2'd0;
    else if ((mode_q == ENG_RESULT) && rd_req)
      ptr_d = (ptr_q == 2'd2) ? 2'd0 : ptr_q + 2'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      mode_q <= ENG_DATA;
    else if (mode_en)
      mode_q <= mode_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      ptr_q   <= 2'd0;
    end else begin
      armed_q <= armed_d;
      ptr_q   <= ptr_d;
    end
  end

endmodule

// File: rtl/nand_ecc_half.sv
module nand_ecc_half #(
  parameter int IDX_W = 8,
  localparam int LP_W = 2 * IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic [IDX_W-1:0] idx,
  input  logic [7:0]       byte_in,
  output logic [LP_W-1:0]  line_out,
  output logic [7:0]       col_out
);

  logic [LP_W-1:0] lp_q, lp_d;
  logic [5:0]      cp_q, cp_d;
  logic            row_par;

  always_comb begin
    row_par = ^byte_in;
    lp_d    = lp_q;
    for (int k = 0; k < IDX_W; k++) begin
      if (idx[k])
        lp_d[2*k+1] = lp_q[2*k+1] ^ row_par;
      else
        lp_d[2*k]   = lp_q[2*k] ^ row_par;
    end
  end

  always_comb begin
    cp_d = cp_q;
    for (int m = 0; m < 3; m++) begin
      for (int j = 0; j < 8; j++) begin
        if (((j >> m) & 1) == 1)
          cp_d[2*m+1] = cp_d[2*m+1] ^ byte_in[j];
        else
          cp_d[2*m]   = cp_d[2*m] ^ byte_in[j];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lp_q <= '0;
      cp_q <= '0;
    end else if (clr) begin
      lp_q <= '0;
      cp_q <= '0;
    end else if (en) begin
      lp_q <= lp_d;
      cp_q <= cp_d;
    end
  end

  assign line_out = ~lp_q;
  assign col_out  = {~cp_q, 2'b11};

endmodule

// File: rtl/nand_ecc_pack.sv
module nand_ecc_pack (
  input  logic        active,
  input  logic [1:0]  ptr,
  input  logic [15:0] line0,
  input  logic [7:0]  col0,
  input  logic [15:0] line1,
  input  logic [7:0]  col1,
  output logic [15:0] word
);

  always_comb begin
    word = 16'h0000;
    if (active) begin
      case (ptr)
        2'd0:    word = line0;
        2'd1:    word = {line1[7:0], col0};
        2'd2:    word = {col1, line1[15:8]};
        default: word = 16'h0000;
      endcase
    end
  end

endmodule

// File: rtl/nand_ecc_engine.sv
module nand_ecc_engine
  import nand_ecc_pkg::*;
#(
  parameter int HALF_BYTES = 256,
  localparam int HALVES      = 2,
  localparam int IDX_W       = $clog2(HALF_BYTES),
  localparam int LP_W        = 2 * IDX_W,
  localparam int TOTAL_BYTES = HALVES * HALF_BYTES,
  localparam int CNT_W       = $clog2(TOTAL_BYTES) + 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        mode_we,
  input  logic [7:0]  mode_wdata,
  input  logic        data_valid,
  input  logic [7:0]  data_byte,
  input  logic        rd_req,
  output logic [15:0] rd_data
);

  eng_mode_e        mode_q;
  logic             armed_q;
  logic [1:0]       ptr_q;
  logic             clr;
  logic             res_mode;
  logic             accept;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [LP_W-1:0]  line_w [HALVES];
  logic [7:0]       col_w  [HALVES];

  nand_ecc_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_we    (mode_we),
    .mode_wdata (mode_wdata),
    .rd_req     (rd_req),
    .mode_q     (mode_q),
    .armed_q    (armed_q),
    .ptr_q      (ptr_q),
    .clr        (clr)
  );

  assign res_mode = (mode_q == ENG_RESULT);
  assign accept   = data_valid && armed_q && (mode_q == ENG_CALC)
                    && (cnt_q < CNT_W'(TOTAL_BYTES));

  always_comb begin
    cnt_d = cnt_q;
    if (clr)
      cnt_d = '0;
    else if (accept)
      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else
      cnt_q <= cnt_d;
  end

  for (genvar g = 0; g < HALVES; g++) begin : g_half
    logic half_en;
    assign half_en = accept && (cnt_q[IDX_W] == g[0]);
    nand_ecc_half #(.IDX_W(IDX_W)) u_half (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (clr),
      .en       (half_en),
      .idx      (cnt_q[IDX_W-1:0]),
      .byte_in  (data_byte),
      .line_out (line_w[g]),
      .col_out  (col_w[g])
    );
  end

  nand_ecc_pack u_pack (
    .active (res_mode),
    .ptr    (ptr_q),
    .line0  (line_w[0][15:0]),
    .col0   (col_w[0]),
    .line1  (line_w[1][15:0]),
    .col1   (col_w[1]),
    .word   (rd_data)
  );

endmodule

// File: rtl/nand_ecc_chk.sv
module nand_ecc_chk
  import nand_ecc_pkg::*;
#(
  parameter int CNT_W = 10,
  parameter int TOTAL = 512
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mode_we,
  input logic [7:0]       mode_wdata,
  input logic             rd_req,
  input logic [15:0]      rd_data,
  input logic             res_mode,
  input logic             armed,
  input logic [1:0]       ptr,
  input logic [CNT_W-1:0] cnt
);

  AST_PTR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    ptr != 2'd3);  // R10

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (res_mode && rd_req && !mode_we) |=>
      (ptr == (($past(ptr) == 2'd2) ? 2'd0 : $past(ptr) + 2'd1)));  // R10

  AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(TOTAL));  // R8

  AST_UNARMED_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> (cnt == '0));  // R3

  AST_CLEAR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_we && mode_wdata == CODE_CLEAR) |=> (cnt == '0 && !armed));  // R2

  AST_DATA_MODE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !res_mode |-> (rd_data == 16'h0000));  // R11

  AST_COL_FIXED_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (res_mode && ptr == 2'd1) |-> (rd_data[1:0] == 2'b11));  // R6

endmodule

bind nand_ecc_engine nand_ecc_chk #(.CNT_W(CNT_W), .TOTAL(TOTAL_BYTES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mode_we    (mode_we),
  .mode_wdata (mode_wdata),
  .rd_req     (rd_req),
  .rd_data    (rd_data),
  .res_mode   (res_mode),
  .armed      (armed_q),
  .ptr        (ptr_q),
  .cnt        (cnt_q)
);

// File: tb/tb_nand_ecc_engine.sv
module tb_nand_ecc_engine;

  localparam int CLK_PERIOD = 10;
  localparam int PAGE = 512;

  logic        clk;
  logic        rst_n;
  logic        mode_we;
  logic [7:0]  mode_wdata;
  logic        data_valid;
  logic [7:0]  data_byte;
  logic        rd_req;
  logic [15:0] rd_data;

  int checks;
  int errors;
  logic [7:0]  page [PAGE];
  logic [15:0] exp_w [3];
  logic [15:0] got_w [3];

  nand_ecc_engine dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_we    (mode_we),
    .mode_wdata (mode_wdata),
    .data_valid (data_valid),
    .data_byte  (data_byte),
    .rd_req     (rd_req),
    .rd_data    (rd_data)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD / 2) clk = ~clk;
  end

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic put_mode(input logic [7:0] code);
    @(negedge clk);
    mode_we = 1'b1;
    mode_wdata = code;
    @(negedge clk);
    mode_we = 1'b0;
  endtask

  task automatic put_byte(input logic [7:0] b);
    data_valid = 1'b1;
    data_byte = b;
    @(negedge clk);
    data_valid = 1'b0;
  endtask

  task automatic read_word(output logic [15:0] w);
    w = rd_data;
    rd_req = 1'b1;
    @(negedge clk);
    rd_req = 1'b0;
  endtask

  // Reference: the parity definitions of R5..R7 and the packing of R9
  task automatic model(input int n);
    logic [15:0] lp [2];
    logic [5:0]  cp [2];
    logic [7:0]  colb [2];
    lp[0] = '0; lp[1] = '0; cp[0] = '0; cp[1] = '0;
    for (int i = 0; i < n && i < PAGE; i++) begin
      int h = i / 256;
      int x = i % 256;
      int rp = 0;
      for (int j = 0; j < 8; j++) rp ^= int'(page[i][j]);
      for (int k = 0; k < 8; k++) begin
        if ((x >> k) % 2 == 1) lp[h][2*k+1] ^= rp[0];
        else                   lp[h][2*k]   ^= rp[0];
      end
      for (int j = 0; j < 8; j++)
        for (int m = 0; m < 3; m++) begin
          if ((j >> m) % 2 == 1) cp[h][2*m+1] ^= page[i][j];
          else                   cp[h][2*m]   ^= page[i][j];
        end
    end
    for (int h = 0; h < 2; h++) begin
      lp[h] = ~lp[h];
      colb[h] = {~cp[h], 2'b11};
    end
    exp_w[0] = lp[0];
    exp_w[1] = {lp[1][7:0], colb[0]};
    exp_w[2] = {colb[1], lp[1][15:8]};
  endtask

  task automatic read_all();
    put_mode(8'hD4);
    for (int i = 0; i < 3; i++) read_word(got_w[i]);
  endtask

  task automatic run_page(input int n, input string req);
    put_mode(8'hF4);
    read_word(got_w[0]);           // dummy read arms
    put_mode(8'hB4);
    for (int i = 0; i < n; i++) put_byte(i < PAGE ? page[i] : 8'hA5);
    model(n);
    read_all();
    for (int i = 0; i < 3; i++) check(req, got_w[i], exp_w[i]);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    checks = 0; errors = 0;
    mode_we = 0; mode_wdata = 0; data_valid = 0; data_byte = 0; rd_req = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    check("R1 idle data", rd_data, 16'h0000);
    read_all();
    for (int i = 0; i < 3; i++) check("R1 R7 empty ecc", got_w[i], 16'hFFFF);

    // R7: erased page
    for (int i = 0; i < PAGE; i++) page[i] = 8'hFF;
    run_page(PAGE, "R7 erased page");

    // R5 R6 R8 R9: single-bit sweeps across and at the half boundaries
    for (int b = 0; b < 8; b++) begin
      int pos [5];
      pos[0] = 0; pos[1] = 255; pos[2] = 256; pos[3] = 511; pos[4] = 37 + 59 * b;
      for (int p = 0; p < 5; p++) begin
        for (int i = 0; i < PAGE; i++) page[i] = 8'h00;
        page[pos[p]] = 8'h01 << b;
        run_page(PAGE, "R5 R6 R9 single bit");
      end
    end

    // R4 R5 R6: patterned pages
    for (int s = 0; s < 8; s++) begin
      for (int i = 0; i < PAGE; i++) page[i] = 8'((i * (2 * s + 3)) ^ (i >> 3) ^ (s * 41));
      run_page(PAGE, "R4 R5 pattern page");
    end

    // R8: bytes past 512 ignored
    run_page(PAGE + 9, "R8 overflow bytes");
    // R8: short stream fills half 0 only partly
    run_page(100, "R8 short stream");

    // R3: bytes before the dummy read are dropped
    put_mode(8'hF4);
    put_mode(8'hB4);
    for (int i = 0; i < 20; i++) put_byte(8'h5A + 8'(i));
    read_word(got_w[0]);
    for (int i = 0; i < PAGE; i++) put_byte(page[i]);
    model(PAGE);
    read_all();
    for (int i = 0; i < 3; i++) check("R3 pre-arm bytes ignored", got_w[i], exp_w[i]);

    // R10: pointer wraps and resets on re-entry
    read_word(got_w[0]);
    check("R10 wrap to word0", got_w[0], exp_w[0]);
    read_word(got_w[1]);
    check("R10 after wrap word1", got_w[1], exp_w[1]);
    put_mode(8'hD4);
    check("R10 re-entry word0", rd_data, exp_w[0]);

    // R12: unknown code leaves mode and pointer alone
    read_word(got_w[0]);
    put_mode(8'h55);
    check("R12 unknown code keeps word1", rd_data, exp_w[1]);

    // R11: data mode, bytes ignored, parity kept
    put_mode(8'h94);
    check("R11 data mode zero", rd_data, 16'h0000);
    for (int i = 0; i < 10; i++) put_byte(8'hC3);
    read_all();
    for (int i = 0; i < 3; i++) check("R11 parity kept", got_w[i], exp_w[i]);

    // R2: clear empties parity
    put_mode(8'hF4);
    read_all();
    for (int i = 0; i < 3; i++) check("R2 cleared", got_w[i], 16'hFFFF);

    // R4: calc mode without clear re-arm path, bytes in result mode ignored
    put_mode(8'hD4);
    for (int i = 0; i < 5; i++) put_byte(8'h01);
    read_all();
    for (int i = 0; i < 3; i++) check("R4 result mode bytes ignored", got_w[i], 16'hFFFF);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule